// File: doc/BRIEF.md
# Overlapped Lane-Parallel All-Pole Recursion

This block evaluates the feedback half of a recursive filter, y[k] = yb[k] + Σ a[j]·y[k−j] for j = 1 … J−1, on a row of 16 multiply-accumulate lanes. Output y[k] owns lane k mod 16 from the cycle its feed-forward term yb[k] is loaded until the cycle it is finished. Each cycle every lane multiplies its current coefficient by one shared value, the most recently finished output, and adds the product to its running sum. Lanes are reused round-robin, so a lane that finishes one output is taken up by the output 16 positions later while the other lanes are still working; successive groups of 16 outputs therefore overlap in time and the row never drains between groups.

Coefficients arrive one per cycle at lane 0 from an external coefficient memory with a one-cycle registered read and ripple upward one lane per cycle. The memory is read in a descending, repeating index pattern, and entries beyond the configured tap count are forced to zero on entry, so lanes that have no work in a cycle add nothing. A run is launched with a start pulse that captures the tap count and the run length; the feed-forward samples are then taken one per cycle and the results leave as a valid-qualified stream with one result per cycle.

Top module: `overlap_iir_lanes`

## Requirements
- R1: While reset is held and after its release, busy, yb_take and y_valid are 0.
- R2: For a run with tap count N (1 … 16) and length K, the block emits exactly K results y[0..K−1], where y[k] = yb[k] + Σ_{j=1..N} ((a[j]·y[k−j]) >>> FRAC) with y[m] = 0 for m < 0, each product truncated to DW bits and sums wrapping at DW bits; a[j] is the signed word stored at coefficient address j−1.
- R3: If start is sampled at a rising edge in cycle c, y[k] is shown on y_data with y_valid high in cycle c+N+2+k, and y_valid is low in every other cycle.
- R4: In the start cycle coef_addr equals N mod 16, and in each following busy cycle it is one less than in the previous cycle, modulo 16; coef_data is taken as the memory word for the address presented one cycle earlier.
- R5: With N = 16 a lane is reloaded with a fresh yb in the same cycle its previous output is read, and all results still follow R2; after a read the lane restarts from zero.
- R6: With N = 1 each result depends only on yb[k] and y[k−1] as in R2.
- R7: yb_take is high in cycles c+1 … c+K and low in cycle c+K+1; yb_data is sampled in each cycle where yb_take is high, in order of k.
- R8: busy is high through cycle c+K+N and low in cycle c+K+N+1; a later run is not affected by any earlier run.
- R9: A start pulse while busy is high is ignored: the run in progress keeps its tap count, length and results.
- R10: Coefficient words at addresses N … 15 have no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a run when idle |
| ntaps_in | input | 5 | Tap count N (1 … 16), captured at start |
| len_in | input | 16 | Run length K (at least 1), captured at start |
| busy | output | 1 | Run in progress |
| yb_take | output | 1 | yb_data is consumed this cycle |
| yb_data | input | 20 | Signed feed-forward sample yb[k] |
| coef_addr | output | 4 | Coefficient memory read address |
| coef_data | input | 12 | Signed coefficient word, Q format with 8 fraction bits, one cycle after its address |
| y_valid | output | 1 | y_data holds a result |
| y_data | output | 20 | Signed result y[k] |

## Verification
The bench builds the block with its default sizing of 16 lanes, 20-bit data and 12-bit coefficients with 8 fraction bits, and varies the tap count at run time over 1, 3, 5 and 16. That brings within reach the single-tap case, partially filled lanes where idle lanes must add nothing even with non-zero words in the unused memory entries, and the fully packed case in which a lane is read and reloaded in the same cycle. Back-to-back runs and a start pulse injected mid-run cover restart cleanliness and the ignore rule, while the exact cycle of every result checks the overlap timing.

// File: rtl/oil_pkg.sv
// Shared definitions for the overlapped lane recursion block.
// Assumes nothing beyond the types declared here.
package oil_pkg;
    // Run state of the sequencer
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/oil_sequencer.sv
// Run sequencer: captures tap count and length, keeps the step counter and
// the two rotating lane pointers (lane being loaded, lane being finished).
// Assumes NL is a power of two and the tap count lies in 1..NL.
module oil_sequencer
    import oil_pkg::*;
#(
    parameter int NL = 16,
    parameter int LW = 16,
    localparam int SW  = $clog2(NL),
    localparam int TW  = $clog2(NL + 1),
    localparam int TCW = LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] ntaps_in,
    input  logic [LW-1:0] len_in,
    output logic          go,
    output logic          busy,
    output logic [TW-1:0] ntaps_q,
    output logic          init_en,
    output logic [SW-1:0] init_slot,
    output logic          rd_en,
    output logic [SW-1:0] rd_slot
);
    run_state_e     state_q;
    logic [TCW-1:0] t_q;
    logic [LW-1:0]  len_q;
    logic           last;

    // Decode run control from the step counter
    always_comb begin
        busy    = (state_q == ST_RUN);
        go      = start && !busy;
        init_en = busy && (t_q < TCW'(len_q));
        rd_en   = busy && (t_q >= TCW'(ntaps_q));
        last    = (t_q == TCW'(len_q) + TCW'(ntaps_q) - TCW'(1));
    end

    // Advance the counter and both lane pointers once per busy cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            t_q       <= '0;
            len_q     <= '0;
            ntaps_q   <= '0;
            init_slot <= '0;
            rd_slot   <= '0;
        end else if (go) begin
            state_q   <= ST_RUN;
            t_q       <= '0;
            len_q     <= len_in;
            ntaps_q   <= ntaps_in;
            init_slot <= '0;
            rd_slot   <= SW'(TW'(NL) - ntaps_in);
        end else if (busy) begin
            t_q       <= t_q + TCW'(1);
            init_slot <= init_slot + SW'(1);
            rd_slot   <= rd_slot + SW'(1);
            if (last) state_q <= ST_IDLE;
        end
    end

    // R5
    slot_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_en && rd_en && ntaps_q != TW'(NL)) |-> (init_slot != rd_slot));

    // R3
    rd_slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (rd_slot == $past(rd_slot) + 1'b1));
endmodule

// File: rtl/oil_coef_feed.sv
// Coefficient feed: issues descending memory addresses, zeroes words beyond
// the tap count on entry, and ripples coefficients up one lane per cycle.
// Assumes the memory returns the word one cycle after its address.
module oil_coef_feed #(
    parameter int NL = 16,
    parameter int CW = 12,
    localparam int SW = $clog2(NL),
    localparam int TW = $clog2(NL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic                 busy,
    input  logic [TW-1:0]        ntaps_in,
    input  logic [TW-1:0]        ntaps_q,
    input  logic signed [CW-1:0] coef_data,
    output logic [SW-1:0]        coef_addr,
    output logic signed [CW-1:0] cv [NL]
);
    logic [SW-1:0] idx_q;
    logic          mask_q;
    logic [TW-1:0] ntaps_eff;

    // Select the address for the coefficient that enters next cycle
    always_comb begin
        coef_addr = go ? SW'(ntaps_in) : idx_q;
        ntaps_eff = go ? ntaps_in : ntaps_q;
    end

    // Step the address down and remember whether the word is beyond the taps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mask_q <= 1'b1;
        end else if (go || busy) begin
            idx_q  <= coef_addr - SW'(1);
            mask_q <= (TW'(coef_addr) >= ntaps_eff);
        end
    end

    // Lane 0 takes the (possibly zeroed) memory word directly
    assign cv[0] = mask_q ? '0 : coef_data;

    for (genvar i = 1; i < NL; i++) begin : g_stage
        logic signed [CW-1:0] sr_q;
        // Ripple the coefficient one lane upward per busy cycle
        always_ff @(posedge clk) begin
            if (!rst_n || go) sr_q <= '0;
            else if (busy)    sr_q <= cv[i-1];
        end
        assign cv[i] = sr_q;
    end

    // R4
    addr_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (coef_addr == $past(coef_addr) - 1'b1));
endmodule

// File: rtl/oil_lane_array.sv
// Lane array: NL accumulators, each multiplying its coefficient by the shared
// broadcast value; one lane is loaded and one lane is finished per cycle.
// Assumes load and finish never target the same lane unless all lanes are in use,
// in which case the load wins.
module oil_lane_array #(
    parameter int NL   = 16,
    parameter int DW   = 20,
    parameter int CW   = 12,
    parameter int FRAC = 8,
    localparam int SW  = $clog2(NL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 busy,
    input  logic signed [CW-1:0] cv [NL],
    input  logic signed [DW-1:0] bcast,
    input  logic                 init_en,
    input  logic [SW-1:0]        init_slot,
    input  logic signed [DW-1:0] yb,
    input  logic                 rd_en,
    input  logic [SW-1:0]        rd_slot,
    output logic signed [DW-1:0] rd_sum
);
    logic signed [DW-1:0] acc  [NL];
    logic signed [DW-1:0] prod [NL];

    for (genvar i = 0; i < NL; i++) begin : g_lane
        localparam logic [SW-1:0] ME = SW'(i);
        logic signed [CW+DW-1:0] full;

        // Scaled product of this lane's coefficient and the broadcast value
        always_comb begin
            full    = (CW+DW)'(cv[i]) * (CW+DW)'(bcast);
            prod[i] = DW'(full >>> FRAC);
        end

        // Load, restart or accumulate this lane
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                   acc[i] <= '0;
            else if (busy) begin
                if (init_en && init_slot == ME)    acc[i] <= yb;
                else if (rd_en && rd_slot == ME)   acc[i] <= '0;
                else                               acc[i] <= acc[i] + prod[i];
            end
        end
    end

    // Finished value of the lane being read, including its last product
    assign rd_sum = acc[rd_slot] + prod[rd_slot];

    // R5
    slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && !($past(init_en) && $past(init_slot) == $past(rd_slot)))
        |-> (acc[$past(rd_slot)] == '0));
endmodule

// File: rtl/overlap_iir_lanes.sv
// Top: overlapped lane-parallel all-pole recursion. Wires the sequencer,
// coefficient feed and lane array, and registers the result stream, which
// also serves as the broadcast value for the next cycle.
// Assumes tap count 1..NL, run length at least 1, NL a power of two.
module overlap_iir_lanes #(
    parameter int NL   = 16,
    parameter int DW   = 20,
    parameter int CW   = 12,
    parameter int FRAC = 8,
    parameter int LW   = 16,
    localparam int SW  = $clog2(NL),
    localparam int TW  = $clog2(NL + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [TW-1:0]        ntaps_in,
    input  logic [LW-1:0]        len_in,
    output logic                 busy,
    output logic                 yb_take,
    input  logic signed [DW-1:0] yb_data,
    output logic [SW-1:0]        coef_addr,
    input  logic signed [CW-1:0] coef_data,
    output logic                 y_valid,
    output logic signed [DW-1:0] y_data
);
    logic                 go;
    logic [TW-1:0]        ntaps_q;
    logic                 init_en;
    logic [SW-1:0]        init_slot;
    logic                 rd_en;
    logic [SW-1:0]        rd_slot;
    logic signed [CW-1:0] cv [NL];
    logic signed [DW-1:0] rd_sum;
    logic signed [DW-1:0] y_q;
    logic                 yv_q;

    oil_sequencer #(.NL(NL), .LW(LW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .ntaps_in(ntaps_in),
        .len_in(len_in), .go(go), .busy(busy), .ntaps_q(ntaps_q),
        .init_en(init_en), .init_slot(init_slot), .rd_en(rd_en), .rd_slot(rd_slot)
    );

    oil_coef_feed #(.NL(NL), .CW(CW)) u_feed (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .ntaps_in(ntaps_in),
        .ntaps_q(ntaps_q), .coef_data(coef_data), .coef_addr(coef_addr), .cv(cv)
    );

    oil_lane_array #(.NL(NL), .DW(DW), .CW(CW), .FRAC(FRAC)) u_lanes (
        .clk(clk), .rst_n(rst_n), .clear(go), .busy(busy), .cv(cv), .bcast(y_q),
        .init_en(init_en), .init_slot(init_slot), .yb(yb_data),
        .rd_en(rd_en), .rd_slot(rd_slot), .rd_sum(rd_sum)
    );

    // Register each finished result; it is broadcast to all lanes next cycle
    always_ff @(posedge clk) begin
        if (!rst_n || go) begin
            y_q  <= '0;
            yv_q <= 1'b0;
        end else begin
            yv_q <= rd_en;
            if (rd_en) y_q <= rd_sum;
        end
    end

    assign yb_take = init_en;
    assign y_valid = yv_q;
    assign y_data  = y_q;

    // R3
    out_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> $past(busy));
endmodule

// File: tb/test_overlap_iir_lanes.sv
module test_overlap_iir_lanes;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16, DW = 20, CW = 12, FRAC = 8, LW = 16;
    localparam int SW = $clog2(NL), TW = $clog2(NL + 1);
    localparam int WD_LIMIT = 20000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [TW-1:0]        ntaps_in = '0;
    logic [LW-1:0]        len_in = '0;
    logic                 busy, yb_take, y_valid;
    logic signed [DW-1:0] yb_data = '0;
    logic [SW-1:0]        coef_addr;
    logic signed [CW-1:0] coef_data = '0;
    logic signed [DW-1:0] y_data;

    overlap_iir_lanes #(.NL(NL), .DW(DW), .CW(CW), .FRAC(FRAC), .LW(LW)) i_overlap_iir_lanes (
        .clk(clk), .rst_n(rst_n), .start(start), .ntaps_in(ntaps_in), .len_in(len_in),
        .busy(busy), .yb_take(yb_take), .yb_data(yb_data), .coef_addr(coef_addr),
        .coef_data(coef_data), .y_valid(y_valid), .y_data(y_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int coefs [NL];
    // Coefficient memory with a one-cycle registered read
    always @(posedge clk) coef_data <= CW'(coefs[coef_addr]);

    int n_tests = 0, n_fail = 0;

    typedef struct {
        longint val;
        longint cyc;
        string  tag;
    } exp_t;
    exp_t q[$];

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint wrapdw(longint v);
        logic [DW-1:0] b;
        b = v[DW-1:0];
        return longint'($signed(b));
    endfunction

    // Monitor: pop expected results and compare value and cycle
    always @(negedge clk) begin
        if (rst_n && y_valid) begin
            if (q.size() == 0) begin
                chk(1'b0, "R3", "unexpected y_valid", cyc, -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(longint'(y_data) == e.val, e.tag, "result value", longint'(y_data), e.val);
                chk(cyc == e.cyc, "R3", "result cycle", cyc, e.cyc);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > WD_LIMIT) begin
            chk(1'b0, "R8", "watchdog expired", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Driver: build expected results, launch a run, feed samples, check timing
    task automatic run(int ntaps, int len, int seed, bit garbage, int inject, string tag);
        longint a [1:16];
        longint yb [];
        longint y [];
        longint c;
        int bad_addr = 0, bad_take = 0;
        yb = new[len];
        y  = new[len];
        for (int j = 1; j <= 16; j++) begin
            if (j <= ntaps)   a[j] = longint'(((j * 29 + seed * 7) % 41) - 20);
            else if (garbage) a[j] = longint'(90 + j);
            else              a[j] = 0;
            coefs[j-1] = int'(a[j]);
        end
        for (int i = 0; i < len; i++) yb[i] = longint'((((i * 73 + seed * 19) % 201) - 100) * 8);
        for (int k = 0; k < len; k++) begin
            longint s;
            s = yb[k];
            for (int j = 1; j <= ntaps; j++)
                if (k - j >= 0 && !(j > ntaps)) s += wrapdw((a[j] * y[k-j]) >>> FRAC);
            y[k] = wrapdw(s);
        end
        @(negedge clk);
        c = cyc;
        for (int k = 0; k < len; k++) q.push_back('{val: y[k], cyc: c + ntaps + 2 + k, tag: tag});
        start    = 1'b1;
        ntaps_in = TW'(ntaps);
        len_in   = LW'(len);
        #1;
        if (coef_addr != SW'(ntaps % NL)) bad_addr++;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            start = (i == inject);
            if (i == inject) begin
                ntaps_in = TW'(7);
                len_in   = LW'(3);
            end
            yb_data = DW'(yb[i]);
            if (!yb_take) bad_take++;
            if (i < 20 && coef_addr != SW'(((ntaps - i - 1) % NL + NL) % NL)) bad_addr++;
        end
        chk(bad_addr == 0, "R4", "coefficient address mismatches", bad_addr, 0);
        chk(bad_take == 0, "R7", "cycles without yb_take", bad_take, 0);
        @(negedge clk);
        start = 1'b0;
        yb_data = '0;
        chk(yb_take == 1'b0, "R7", "yb_take after last sample", yb_take, 0);
        repeat (ntaps - 1) @(negedge clk);
        chk(busy == 1'b1, "R8", "busy in last step", busy, 1);
        @(negedge clk);
        chk(busy == 1'b0, "R8", "busy after run", busy, 0);
        repeat (3) @(negedge clk);
        chk(q.size() == 0, tag, "results still outstanding", q.size(), 0);
    endtask

    initial begin
        for (int j = 0; j < NL; j++) coefs[j] = 0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(y_valid == 1'b0, "R1", "y_valid in reset", y_valid, 0);
        chk(yb_take == 1'b0, "R1", "yb_take in reset", yb_take, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && y_valid == 1'b0, "R1", "idle after reset", busy, 0);
        run(5, 40, 1, 1'b0, -1, "R2");
        run(16, 50, 2, 1'b0, -1, "R5");
        run(1, 20, 3, 1'b0, -1, "R6");
        run(5, 30, 4, 1'b0, 6, "R9");
        run(3, 25, 5, 1'b1, -1, "R10");
        run(16, 20, 6, 1'b0, -1, "R8");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule